// File: doc/BRIEF.md
# SPI Status Flags and Interrupt Requests

This block holds the four status flags that sit beside an SPI shift engine: transmit buffer empty, receive buffer full, receive overrun and mode fault. The shift engine reports its events as single-cycle pulses (or, for the mode fault, as a level). The bus side reports its accesses as single-cycle strobes: a status read, a control write, a receive-data read and a transmit-data write. The block combines these into the flag states and two interrupt request lines.

Three of the flags clear only through a two-step access sequence. The first step is a status read taken while the flag is set. The second step is the matching register access. A mode fault clear is abandoned if the fault condition is present at any point in its sequence. When a mode fault is raised, the block also records whether the port was acting as master, so software can tell the two cases apart afterwards.

Top module: `spi_stat_irq`

## Requirements
- R1: After a synchronous active-low reset, tx_empty is 1, and rx_full, overrun, mode_fault and fault_master are 0.
- R2: tx_empty goes to 1 on the clock after ev_tx_load. It goes to 0 on the clock after txd_wr. No other input clears it.
- R3: rx_full goes to 1 on the clock after ev_rx_done. It is cleared only by an rxd_rd that follows a stat_rd taken while rx_full was 1. An rxd_rd with no such earlier read leaves rx_full unchanged.
- R4: overrun goes to 1 on the clock after an ev_rx_done that arrives while rx_full is already 1. It clears with its own status-read-then-rxd_rd sequence, which must begin with a stat_rd taken while overrun was 1.
- R5: mode_fault goes to 1 on the clock after any cycle with fault_cond high. It is cleared by a stat_rd taken while mode_fault was 1 and fault_cond was low, followed later by a ctrl_wr.
- R6: If fault_cond is high in the cycle of the status read, in any cycle between the read and the write, or in the write cycle, the mode_fault clear does not happen. A later ctrl_wr then has no effect until a new status read arms the sequence again.
- R7: When mode_fault goes from 0 to 1, fault_master takes the value of is_master from that cycle. At all other times fault_master holds its value.
- R8: A set event in the same cycle as the clearing access wins, and the flag stays 1.
- R9: The second access of a sequence uses up the arming, even when it does not clear the flag. A status read in the same cycle as a second access does not arm the sequence.
- R10: tx_irq = tx_empty AND NOT dma_sel AND tx_ie AND spi_en, combinationally from the current flag and controls.
- R11: rx_irq = (rx_full AND NOT dma_sel AND rx_ie) OR ((overrun OR mode_fault) AND err_ie), combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spi_en | input | 1 | Port enabled |
| dma_sel | input | 1 | Data moves by DMA; blocks the data interrupts |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| is_master | input | 1 | Current master-select setting |
| stat_rd | input | 1 | Status register read strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| rxd_rd | input | 1 | Receive data read strobe |
| txd_wr | input | 1 | Transmit data write strobe |
| ev_tx_load | input | 1 | Shifter took the transmit byte |
| ev_rx_done | input | 1 | Shifter completed a received byte |
| fault_cond | input | 1 | Mode-fault condition present (level) |
| tx_empty | output | 1 | Transmit buffer empty flag |
| rx_full | output | 1 | Receive buffer full flag |
| overrun | output | 1 | Receive overrun flag |
| mode_fault | output | 1 | Mode fault flag |
| fault_master | output | 1 | is_master as recorded when the mode fault was raised |
| tx_irq | output | 1 | Transmitter interrupt request |
| rx_irq | output | 1 | Receiver/error interrupt request |

## Verification
The bench targets the following corner cases, and each one exposes a specific failure.
- A data read or control write with no earlier qualifying status read: a design without arming would clear the flag here.
- A status read and a second access landing in the same cycle: a design with the wrong priority would leave a stale arming that clears the flag one access too early.
- A fault pulse arriving between the status read and the control write: a design that ignores the void rule would drop mode_fault while the fault is live.
- A byte completing in the very cycle of a clear: a design where the clear takes priority would lose the new byte's rx_full and skip the overrun.

// File: rtl/spi_stat_pkg.sv
// Package: shared indices for the receive-side flag array.
// Assumes the two receive-side flags share one clearing access.
package spi_stat_pkg;
    localparam int unsigned RXF_FULL = 0;
    localparam int unsigned RXF_OVR  = 1;
    localparam int unsigned NUM_RXF  = 2;
endpackage

// File: rtl/spi_two_step_flag.sv
// Two-step cleared flag: set by an event, armed by a status read seen while
// set, cleared by the matching second access when armed.
// Assumes strobes are single-cycle; void_cond cancels a pending arm.
module spi_two_step_flag #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic arm_rd,
    input  logic clr_acc,
    input  logic void_cond,
    output logic flag
);
    logic flag_q, arm_q;

    // Flag register: set beats clear, clear needs a live arm.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= RST_VAL;
        else if (set_ev)             flag_q <= 1'b1;
        else if (clr_acc && arm_q)   flag_q <= 1'b0;
    end

    // Arm register: second access or void drops it, qualifying read sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)                      arm_q <= 1'b0;
        else if (clr_acc || void_cond)   arm_q <= 1'b0;
        else if (arm_rd && flag_q)       arm_q <= 1'b1;
    end

    assign flag = flag_q;
endmodule

// File: rtl/spi_tx_empty_flag.sv
// Transmit-empty flag: set when the shifter takes the byte, cleared by a
// data write alone. Assumes single-cycle strobes.
module spi_tx_empty_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic load_ev,
    input  logic wr_acc,
    output logic flag
);
    // Flag register with set priority over the write.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b1;
        else if (load_ev)  flag <= 1'b1;
        else if (wr_acc)   flag <= 1'b0;
    end
endmodule

// File: rtl/spi_irq_combine.sv
// Interrupt combiner: gates the flags with the enables into the two request
// lines. Purely combinational; assumes flags come from registers.
module spi_irq_combine (
    input  logic spi_en,
    input  logic dma_sel,
    input  logic tx_ie,
    input  logic rx_ie,
    input  logic err_ie,
    input  logic tx_empty,
    input  logic rx_full,
    input  logic overrun,
    input  logic mode_fault,
    output logic tx_irq,
    output logic rx_irq
);
    logic data_ok;

    // Request equations.
    always_comb begin
        data_ok = !dma_sel;
        tx_irq  = tx_empty && data_ok && tx_ie && spi_en;
        rx_irq  = (rx_full && data_ok && rx_ie) || ((overrun || mode_fault) && err_ie);
    end
endmodule

// File: rtl/spi_stat_irq.sv
// Top: SPI status flags and interrupt requests. Wraps the flag cells, the
// master-at-fault capture and the request combiner.
// Assumes all strobes and events are single-cycle pulses in the clk domain.
module spi_stat_irq
    import spi_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic spi_en,
    input  logic dma_sel,
    input  logic tx_ie,
    input  logic rx_ie,
    input  logic err_ie,
    input  logic is_master,
    input  logic stat_rd,
    input  logic ctrl_wr,
    input  logic rxd_rd,
    input  logic txd_wr,
    input  logic ev_tx_load,
    input  logic ev_rx_done,
    input  logic fault_cond,
    output logic tx_empty,
    output logic rx_full,
    output logic overrun,
    output logic mode_fault,
    output logic fault_master,
    output logic tx_irq,
    output logic rx_irq
);
    logic [NUM_RXF-1:0] rx_set;
    logic [NUM_RXF-1:0] rx_flag;

    // Receive-side set events: overrun needs rx_full already set.
    always_comb begin
        rx_set[RXF_FULL] = ev_rx_done;
        rx_set[RXF_OVR]  = ev_rx_done && rx_flag[RXF_FULL];
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_RXF; gi++) begin : g_rxf
            spi_two_step_flag #(.RST_VAL(1'b0)) u_flag (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_ev    (rx_set[gi]),
                .arm_rd    (stat_rd),
                .clr_acc   (rxd_rd),
                .void_cond (1'b0),
                .flag      (rx_flag[gi])
            );
        end
    endgenerate

    spi_two_step_flag #(.RST_VAL(1'b0)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_ev    (fault_cond),
        .arm_rd    (stat_rd),
        .clr_acc   (ctrl_wr),
        .void_cond (fault_cond),
        .flag      (mode_fault)
    );

    spi_tx_empty_flag u_txe (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_ev (ev_tx_load),
        .wr_acc  (txd_wr),
        .flag    (tx_empty)
    );

    // Record the master setting on the rising of the mode fault.
    always_ff @(posedge clk) begin
        if (!rst_n)                        fault_master <= 1'b0;
        else if (fault_cond && !mode_fault) fault_master <= is_master;
    end

    assign rx_full = rx_flag[RXF_FULL];
    assign overrun = rx_flag[RXF_OVR];

    spi_irq_combine u_irq (
        .spi_en     (spi_en),
        .dma_sel    (dma_sel),
        .tx_ie      (tx_ie),
        .rx_ie      (rx_ie),
        .err_ie     (err_ie),
        .tx_empty   (tx_empty),
        .rx_full    (rx_full),
        .overrun    (overrun),
        .mode_fault (mode_fault),
        .tx_irq     (tx_irq),
        .rx_irq     (rx_irq)
    );
endmodule

// File: rtl/spi_stat_irq_chk.sv
// Checker: temporal properties on the flag block's ports, bound to the top.
module spi_stat_irq_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_en,
    input logic is_master,
    input logic txd_wr,
    input logic ev_tx_load,
    input logic ev_rx_done,
    input logic fault_cond,
    input logic tx_empty,
    input logic rx_full,
    input logic overrun,
    input logic mode_fault,
    input logic fault_master,
    input logic tx_irq
);
    // R2
    txe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_wr && !ev_tx_load) |=> !tx_empty);
    // R2
    txe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !txd_wr) |=> tx_empty);
    // R3
    rxf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_full && !ev_rx_done) |=> !rx_full);
    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_done && rx_full) |=> overrun);
    // R5
    mf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_cond |=> mode_fault);
    // R7
    fm_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_fault) |-> (fault_master == $past(is_master)));
    // R8
    rxf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_done |=> rx_full);
    // R10
    txirq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en |-> !tx_irq);
endmodule

bind spi_stat_irq spi_stat_irq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .spi_en       (spi_en),
    .is_master    (is_master),
    .txd_wr       (txd_wr),
    .ev_tx_load   (ev_tx_load),
    .ev_rx_done   (ev_rx_done),
    .fault_cond   (fault_cond),
    .tx_empty     (tx_empty),
    .rx_full      (rx_full),
    .overrun      (overrun),
    .mode_fault   (mode_fault),
    .fault_master (fault_master),
    .tx_irq       (tx_irq)
);

// File: tb/tb_spi_stat_irq.sv
// Bench: behavioural reference model compared against every output each cycle.
module tb_spi_stat_irq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_en = 0, dma_sel = 0, tx_ie = 0, rx_ie = 0, err_ie = 0, is_master = 0;
    logic stat_rd = 0, ctrl_wr = 0, rxd_rd = 0, txd_wr = 0;
    logic ev_tx_load = 0, ev_rx_done = 0, fault_cond = 0;
    logic tx_empty, rx_full, overrun, mode_fault, fault_master, tx_irq, rx_irq;

    int checks = 0;
    int fails  = 0;

    // Reference state
    int m_te, m_rf, m_ov, m_mf, m_fm, a_rf, a_ov, a_mf;

    // stimulus bit positions
    localparam int B_EN = 12, B_DMA = 11, B_TIE = 10, B_RIE = 9, B_EIE = 8, B_MST = 7;
    localparam int B_SR = 6, B_CW = 5, B_RR = 4, B_TW = 3, B_LD = 2, B_RX = 1, B_FLT = 0;
    localparam logic [12:0] CTL = 13'h1F00;

    always #4 clk = ~clk;

    spi_stat_irq dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        int e_tx, e_rx;
        e_tx = m_te & !dma_sel & tx_ie & spi_en;
        e_rx = (m_rf & !dma_sel & rx_ie) | ((m_ov | m_mf) & err_ie);
        chk("R2 tx_empty", tx_empty, m_te);
        chk("R3 rx_full", rx_full, m_rf);
        chk("R4 overrun", overrun, m_ov);
        chk("R5/R6 mode_fault", mode_fault, m_mf);
        chk("R7 fault_master", fault_master, m_fm);
        chk("R10 tx_irq", tx_irq, e_tx);
        chk("R11 rx_irq", rx_irq, e_rx);
    endtask

    // One cycle: compare at negedge, drive new inputs, advance the model.
    task automatic cyc(input logic [12:0] v);
        int n_te, n_rf, n_ov, n_mf, n_fm, n_arf, n_aov, n_amf;
        @(negedge clk);
        compare_all();
        {spi_en, dma_sel, tx_ie, rx_ie, err_ie, is_master,
         stat_rd, ctrl_wr, rxd_rd, txd_wr, ev_tx_load, ev_rx_done, fault_cond} = v;
        n_te  = v[B_LD] ? 1 : (v[B_TW] ? 0 : m_te);
        n_rf  = v[B_RX] ? 1 : ((v[B_RR] && a_rf != 0) ? 0 : m_rf);
        n_ov  = (v[B_RX] && m_rf != 0) ? 1 : ((v[B_RR] && a_ov != 0) ? 0 : m_ov);
        n_mf  = v[B_FLT] ? 1 : ((v[B_CW] && a_mf != 0) ? 0 : m_mf);
        n_fm  = (v[B_FLT] && m_mf == 0) ? int'(v[B_MST]) : m_fm;
        n_arf = v[B_RR] ? 0 : ((v[B_SR] && m_rf != 0) ? 1 : a_rf);
        n_aov = v[B_RR] ? 0 : ((v[B_SR] && m_ov != 0) ? 1 : a_ov);
        n_amf = (v[B_CW] || v[B_FLT]) ? 0 : ((v[B_SR] && m_mf != 0) ? 1 : a_mf);
        m_te = n_te; m_rf = n_rf; m_ov = n_ov; m_mf = n_mf; m_fm = n_fm;
        a_rf = n_arf; a_ov = n_aov; a_mf = n_amf;
    endtask

    function automatic logic [12:0] b(input int pos);
        return 13'(1) << pos;
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        m_te = 1; m_rf = 0; m_ov = 0; m_mf = 0; m_fm = 0; a_rf = 0; a_ov = 0; a_mf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        @(negedge clk);
        chk("R1 tx_empty reset", tx_empty, 1);
        chk("R1 rx_full reset", rx_full, 0);
        chk("R1 overrun reset", overrun, 0);
        chk("R1 mode_fault reset", mode_fault, 0);
        chk("R1 fault_master reset", fault_master, 0);
        // R2: write clears, load sets, same-cycle load wins (R8)
        cyc(CTL | b(B_TW));
        cyc(CTL);
        cyc(CTL | b(B_LD));
        cyc(CTL | b(B_LD) | b(B_TW));
        cyc(CTL | b(B_SR) | b(B_RR) | b(B_CW));
        // R3: data read without armed read ignored
        cyc(CTL | b(B_RX));
        cyc(CTL | b(B_RR));
        cyc(CTL);
        @(negedge clk); chk("R3 unarmed read ignored", rx_full, 1);
        // R9: status read same cycle as data read does not arm
        cyc(CTL | b(B_SR) | b(B_RR));
        cyc(CTL | b(B_RR));
        // R4: overrun then proper clear of both
        cyc(CTL | b(B_RX));
        cyc(CTL | b(B_SR));
        cyc(CTL | b(B_RR));
        cyc(CTL);
        @(negedge clk);
        chk("R3 cleared by sequence", rx_full, 0);
        chk("R4 cleared by sequence", overrun, 0);
        // R8: completion during clear access
        cyc(CTL | b(B_RX));
        cyc(CTL | b(B_SR));
        cyc(CTL | b(B_RR) | b(B_RX));
        cyc(CTL);
        @(negedge clk); chk("R8 set wins over clear", rx_full, 1);
        // R5/R7: fault as master, clean clear
        cyc(CTL | b(B_MST) | b(B_FLT));
        cyc(CTL);
        @(negedge clk); chk("R7 master recorded", fault_master, 1);
        cyc(CTL | b(B_SR));
        cyc(CTL | b(B_CW));
        cyc(CTL);
        @(negedge clk); chk("R5 fault cleared", mode_fault, 0);
        // R6: fault between read and write voids the clear
        cyc(CTL | b(B_FLT));
        cyc(CTL | b(B_SR));
        cyc(CTL | b(B_FLT));
        cyc(CTL);
        cyc(CTL | b(B_CW));
        cyc(CTL);
        @(negedge clk); chk("R6 voided clear", mode_fault, 1);
        // R6: fault in the status read cycle
        cyc(CTL | b(B_SR) | b(B_FLT));
        cyc(CTL | b(B_CW));
        cyc(CTL);
        @(negedge clk); chk("R6 fault at read", mode_fault, 1);
        // R10/R11: irq gating across control patterns
        for (int k = 0; k < 64; k++) cyc(13'(k) << B_MST);
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [12:0] v;
            v = 13'($urandom) & 13'h1F80;
            if ($urandom_range(0, 99) < 25) v |= b(B_SR);
            if ($urandom_range(0, 99) < 12) v |= b(B_CW);
            if ($urandom_range(0, 99) < 15) v |= b(B_RR);
            if ($urandom_range(0, 99) < 15) v |= b(B_TW);
            if ($urandom_range(0, 99) < 10) v |= b(B_LD);
            if ($urandom_range(0, 99) < 12) v |= b(B_RX);
            if ($urandom_range(0, 99) < 5)  v |= b(B_FLT);
            cyc(v);
        end
        cyc(13'h0);
        @(negedge clk);
        compare_all();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule